// File: doc/BRIEF.md
# Pixel transfer engine with tiled layouts and box downscale

The engine copies one image from a source buffer to a destination buffer. It converts between five pixel formats on the way. It can halve the image horizontally, or in both axes, with a box average. It can mirror the rows vertically. Either side can use a plain row-major layout or 8x8 tiles with Z-order inside each tile. A host loads the configuration on the input pins and pulses `start`. The engine then reads and writes pixels one at a time through a simple memory port and raises `done` for one cycle when it has finished.

The control is a six-state machine. From ST_IDLE, `start` latches the configuration and moves to ST_CHECK. ST_CHECK moves to ST_DONE if the configuration is rejected, and to ST_READ otherwise. ST_READ issues a read and always moves to ST_CAPT. ST_CAPT takes in the returned word and goes back to ST_READ while samples of the current pixel remain; after the last sample it moves to ST_WRITE. ST_WRITE stores the pixel. It then returns to ST_READ for the next pixel, or moves to ST_DONE after the last pixel. ST_DONE always returns to ST_IDLE.

The read port has a fixed latency of one cycle: the word for an address presented with `rd_en` is on `rd_data` in the next cycle. That word holds four bytes from that address upward, little-endian.

Top module: `tile_xfer`

## Requirements
- R1: Format codes are 0 = 32-bit (r in byte 3, g in byte 2, b in byte 1, alpha in byte 0), 1 = 24-bit (b in byte 0, g in byte 1, r in byte 2, alpha read as 255), 2 = 16-bit 5:6:5 (r in bits 15:11, alpha 255), 3 = 16-bit 5:5:5:1 (r 15:11, g 10:6, b 5:1, alpha bit 0), and 4 = 16-bit 4:4:4:4 (r 15:12 down to alpha 3:0). When decoding, a narrow channel is widened to 8 bits by repeating its top bits below it, and a 1-bit alpha becomes 0 or 255.
- R2: Encoding keeps the top bits of each 8-bit channel and uses the same field layout as R1. Each write stores `wr_nbytes` bytes little-endian from `wr_data`, where `wr_nbytes` is 4, 3 or 2 for the output format.
- R3: An input format code of 5 to 7 decodes to all-zero channels and steps through the source 2 bytes per pixel.
- R4: Scale code 0 copies one to one. Code 1 halves the output width. Code 2 halves both output width and output height (the halving is a right shift of the configured value). Output pixel (x, y) takes its source at (x shifted left by the horizontal amount, y shifted left by the vertical amount).
- R5: Code 1 averages the source pixel with the next pixel in memory. Code 2 averages the source pixel with the three pixels that follow it in memory. Each channel is summed and divided with truncation.
- R6: A tiled offset in pixels is (x with low 3 bits cleared)·8 + the interleave of x[2:0] and y[2:0] with x bit 0 as the lowest bit + (y with low 3 bits cleared)·width. This is multiplied by bytes per pixel. A linear offset is (y·width + x)·bytes per pixel. The source uses the configured input width and the destination uses the effective output width.
- R7: The source is tiled unless `lin_in` is set. The destination layout is the opposite of the source while `no_swizzle` is clear, and the same as the source while it is set.
- R8: With `flip` set, output row y is written to destination row (effective height − 1 − y). The source row is unaffected.
- R9: The engine rejects a transfer that has a zero configured dimension, scale code 3, linear input with a non-zero scale code, an output format code above 4, or a zero effective output dimension. A rejected transfer performs no read and no write.
- R10: `done` is high for exactly one cycle after each transfer, including a rejected one. `busy` stays high from the cycle after `start` until `done`. `start` and configuration changes while busy have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| src_base | input | AW | Source byte address |
| dst_base | input | AW | Destination byte address |
| in_w | input | DW | Input width in pixels |
| in_h | input | DW | Input height in pixels |
| out_w | input | DW | Configured output width |
| out_h | input | DW | Configured output height |
| in_fmt | input | 3 | Input format code |
| out_fmt | input | 3 | Output format code |
| scale | input | 2 | Downscale code |
| flip | input | 1 | Vertical mirror of the output |
| lin_in | input | 1 | Source is linear |
| no_swizzle | input | 1 | Keep the destination layout equal to the source layout |
| rd_en | output | 1 | Read request |
| rd_addr | output | AW | Read byte address |
| rd_data | input | 32 | Read word, one cycle after the request |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 32 | Encoded pixel, little-endian |
| wr_nbytes | output | 3 | Bytes to store |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sample counter or accumulator corrupts the channel values of the next write. The error then appears in the destination bytes that pixel writes, within a few cycles. A wrong row or column counter moves writes to other offsets or changes how many writes a transfer makes, and this is seen in the write count at `done`. A wrong rejection decision shows as stray reads, or as missing writes, right after ST_CHECK. The sweeps compare the full destination image and the read and write counts after every transfer.

// File: rtl/tile_xfer_pkg.sv
package tile_xfer_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic [7:0] a;
    } rgba_t;

    localparam logic [2:0] FMT_W32  = 3'd0;
    localparam logic [2:0] FMT_W24  = 3'd1;
    localparam logic [2:0] FMT_565  = 3'd2;
    localparam logic [2:0] FMT_5551 = 3'd3;
    localparam logic [2:0] FMT_4444 = 3'd4;

    localparam logic [1:0] SC_NONE = 2'd0;
    localparam logic [1:0] SC_X    = 2'd1;
    localparam logic [1:0] SC_XY   = 2'd2;

    function automatic logic [2:0] fmt_bytes(input logic [2:0] f);
        case (f)
            FMT_W32: return 3'd4;
            FMT_W24: return 3'd3;
            default: return 3'd2;
        endcase
    endfunction

    // pixel index inside a tiled surface of the given row width
    function automatic logic [31:0] tile_index(input logic [31:0] x, input logic [31:0] y,
                                               input logic [31:0] w);
        logic [31:0] inner;
        inner = {26'd0, y[2], x[2], y[1], x[1], y[0], x[0]};
        return {x[28:3], 6'd0} + inner + ({y[31:3], 3'd0} * w);
    endfunction

endpackage

// File: rtl/tile_xfer_decode.sv
module tile_xfer_decode
    import tile_xfer_pkg::*;
(
    input  logic [2:0]  fmt,
    input  logic [31:0] word,
    output rgba_t       px
);
    always_comb begin
        px = '0;
        case (fmt)
            FMT_W32:  px = '{r: word[31:24], g: word[23:16], b: word[15:8], a: word[7:0]};
            FMT_W24:  px = '{r: word[23:16], g: word[15:8], b: word[7:0], a: 8'hFF};
            FMT_565:  px = '{r: {word[15:11], word[15:13]}, g: {word[10:5], word[10:9]},
                             b: {word[4:0], word[4:2]}, a: 8'hFF};
            FMT_5551: px = '{r: {word[15:11], word[15:13]}, g: {word[10:6], word[10:8]},
                             b: {word[5:1], word[5:3]}, a: {8{word[0]}}};
            FMT_4444: px = '{r: {2{word[15:12]}}, g: {2{word[11:8]}},
                             b: {2{word[7:4]}}, a: {2{word[3:0]}}};
            default:  px = '0;
        endcase
    end
endmodule

// File: rtl/tile_xfer_encode.sv
module tile_xfer_encode
    import tile_xfer_pkg::*;
(
    input  logic [2:0]  fmt,
    input  rgba_t       px,
    output logic [31:0] word
);
    always_comb begin
        word = '0;
        case (fmt)
            FMT_W32:  word = {px.r, px.g, px.b, px.a};
            FMT_W24:  word = {8'd0, px.r, px.g, px.b};
            FMT_565:  word = {16'd0, px.r[7:3], px.g[7:2], px.b[7:3]};
            FMT_5551: word = {16'd0, px.r[7:3], px.g[7:3], px.b[7:3], px.a[7]};
            FMT_4444: word = {16'd0, px.r[7:4], px.g[7:4], px.b[7:4], px.a[7:4]};
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/tile_xfer_addr.sv
module tile_xfer_addr
    import tile_xfer_pkg::*;
#(
    parameter int DW = 10,
    parameter int AW = 32
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] in_w,
    input  logic [DW-1:0] ow,
    input  logic [DW-1:0] oh,
    input  logic          hs,
    input  logic          vs,
    input  logic          flip,
    input  logic          src_tiled,
    input  logic          dst_tiled,
    input  logic [2:0]    sbpp,
    input  logic [2:0]    dbpp,
    output logic [AW-1:0] src_off,
    output logic [AW-1:0] dst_off
);
    logic [31:0] ix, iy, ox, oy, iw, ew, s_idx, d_idx;

    always_comb begin
        ix = 32'(x) << hs;
        iy = 32'(y) << vs;
        ox = 32'(x);
        oy = flip ? (32'(oh) - 32'(y) - 32'd1) : 32'(y);
        iw = 32'(in_w);
        ew = 32'(ow);
        s_idx = src_tiled ? tile_index(ix, iy, iw) : (iy * iw + ix);
        d_idx = dst_tiled ? tile_index(ox, oy, ew) : (oy * ew + ox);
        src_off = AW'(s_idx * 32'(sbpp));
        dst_off = AW'(d_idx * 32'(dbpp));
    end
endmodule

// File: rtl/tile_xfer.sv
module tile_xfer
    import tile_xfer_pkg::*;
#(
    parameter int DW = 10,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [DW-1:0] in_w,
    input  logic [DW-1:0] in_h,
    input  logic [DW-1:0] out_w,
    input  logic [DW-1:0] out_h,
    input  logic [2:0]    in_fmt,
    input  logic [2:0]    out_fmt,
    input  logic [1:0]    scale,
    input  logic          flip,
    input  logic          lin_in,
    input  logic          no_swizzle,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic [2:0]    wr_nbytes,
    output logic          busy,
    output logic          done
);
    localparam int NCH = 4;
    localparam int CW  = 8 + 2;
    localparam int PW  = 2 * DW;

    typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_READ, ST_CAPT, ST_WRITE, ST_DONE} st_e;
    st_e st_q, st_d;

    logic [AW-1:0] src_base_q, dst_base_q;
    logic [DW-1:0] in_w_q, in_h_q, out_w_q, out_h_q;
    logic [2:0]    in_fmt_q, out_fmt_q;
    logic [1:0]    scale_q;
    logic          flip_q, lin_q, noswz_q;

    logic [DW-1:0] x_q, y_q, ow, oh;
    logic [1:0]    k_q, last_k;
    logic          hs, vs, reject, last_x, last_y;
    logic [2:0]    sbpp, dbpp;
    logic [AW-1:0] src_off, dst_off;

    rgba_t              dec_px, avg_px;
    logic [NCH-1:0][7:0] dec_ch, avg_ch;
    logic [NCH-1:0][CW-1:0] acc_q;
    logic [31:0]        enc_word;

    assign hs     = (scale_q == SC_X) || (scale_q == SC_XY);
    assign vs     = (scale_q == SC_XY);
    assign ow     = out_w_q >> hs;
    assign oh     = out_h_q >> vs;
    assign last_k = {vs, hs};
    assign sbpp   = fmt_bytes(in_fmt_q);
    assign dbpp   = fmt_bytes(out_fmt_q);
    assign last_x = (x_q == ow - 1'b1);
    assign last_y = (y_q == oh - 1'b1);
    assign reject = (in_w_q == '0) || (in_h_q == '0) || (out_w_q == '0) || (out_h_q == '0) ||
                    (scale_q > SC_XY) || (lin_q && scale_q != SC_NONE) ||
                    (out_fmt_q > FMT_4444) || (ow == '0) || (oh == '0);

    tile_xfer_addr #(.DW(DW), .AW(AW)) u_addr (
        .x(x_q), .y(y_q), .in_w(in_w_q), .ow(ow), .oh(oh), .hs(hs), .vs(vs),
        .flip(flip_q), .src_tiled(!lin_q), .dst_tiled(lin_q ^ noswz_q),
        .sbpp(sbpp), .dbpp(dbpp), .src_off(src_off), .dst_off(dst_off)
    );

    tile_xfer_decode u_dec (.fmt(in_fmt_q), .word(rd_data), .px(dec_px));
    tile_xfer_encode u_enc (.fmt(out_fmt_q), .px(avg_px), .word(enc_word));

    assign dec_ch = dec_px;
    assign avg_px = rgba_t'(avg_ch);

    // per-channel box accumulator
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc_q[c] <= '0;
            else if (st_q == ST_CAPT)
                acc_q[c] <= ((k_q == 2'd0) ? CW'(0) : acc_q[c]) + CW'(dec_ch[c]);
        end
        assign avg_ch[c] = 8'(acc_q[c] >> ({1'b0, hs} + {1'b0, vs}));
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_CHECK;
            ST_CHECK: st_d = reject ? ST_DONE : ST_READ;
            ST_READ:  st_d = ST_CAPT;
            ST_CAPT:  st_d = (k_q == last_k) ? ST_WRITE : ST_READ;
            ST_WRITE: st_d = (last_x && last_y) ? ST_DONE : ST_READ;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // configuration and pixel counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base_q <= '0; dst_base_q <= '0;
            in_w_q <= '0; in_h_q <= '0; out_w_q <= '0; out_h_q <= '0;
            in_fmt_q <= '0; out_fmt_q <= '0; scale_q <= '0;
            flip_q <= 1'b0; lin_q <= 1'b0; noswz_q <= 1'b0;
            x_q <= '0; y_q <= '0; k_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    src_base_q <= src_base; dst_base_q <= dst_base;
                    in_w_q <= in_w; in_h_q <= in_h; out_w_q <= out_w; out_h_q <= out_h;
                    in_fmt_q <= in_fmt; out_fmt_q <= out_fmt; scale_q <= scale;
                    flip_q <= flip; lin_q <= lin_in; noswz_q <= no_swizzle;
                end
                ST_CHECK: begin
                    x_q <= '0; y_q <= '0; k_q <= '0;
                end
                ST_CAPT: if (k_q != last_k) k_q <= k_q + 2'd1;
                ST_WRITE: begin
                    k_q <= '0;
                    if (last_x) begin
                        x_q <= '0;
                        y_q <= y_q + 1'b1;
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_en     = (st_q == ST_READ);
        rd_addr   = src_base_q + src_off + AW'(k_q) * AW'(sbpp);
        wr_en     = (st_q == ST_WRITE);
        wr_addr   = dst_base_q + dst_off;
        wr_data   = enc_word;
        wr_nbytes = dbpp;
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
    end

    // writes issued in the current transfer, for the bound check
    logic [PW-1:0] wr_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               wr_cnt_q <= '0;
        else if (st_q == ST_CHECK) wr_cnt_q <= '0;
        else if (wr_en)           wr_cnt_q <= wr_cnt_q + 1'b1;
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en));
    assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_wr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_cnt_q < PW'(ow) * PW'(oh)));
    assert_wr_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en, 2) && !$past(rd_en)));
    assert_reject_noread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHECK && reject) |=> (done && !rd_en));

endmodule

// File: tb/tile_xfer_tb.sv
module tile_xfer_tb;
    localparam int DW = 10;
    localparam int AW = 32;
    localparam logic [AW-1:0] SRC_BASE = 32'h0000_0100;
    localparam logic [AW-1:0] DST_BASE = 32'h0000_3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic start = 1'b0;
    logic [AW-1:0] src_base = SRC_BASE, dst_base = DST_BASE;
    logic [DW-1:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
    logic [2:0] in_fmt = '0, out_fmt = '0;
    logic [1:0] scale = '0;
    logic flip = 1'b0, lin_in = 1'b0, no_swizzle = 1'b0;
    logic rd_en, wr_en, busy, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0] rd_data = '0, wr_data;
    logic [2:0] wr_nbytes;

    tile_xfer #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
        .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h), .in_fmt(in_fmt),
        .out_fmt(out_fmt), .scale(scale), .flip(flip), .lin_in(lin_in),
        .no_swizzle(no_swizzle), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nbytes(wr_nbytes),
        .busy(busy), .done(done)
    );

    logic [7:0] smem [4096];
    logic [7:0] dmem [4096];
    logic [7:0] emem [4096];
    int checks = 0, failures = 0, cyc = 0;

    // memory model: one-cycle read latency, byte writes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en)
            rd_data <= {smem[(rd_addr + 3) & 4095], smem[(rd_addr + 2) & 4095],
                        smem[(rd_addr + 1) & 4095], smem[rd_addr & 4095]};
        if (wr_en)
            for (int i = 0; i < int'(wr_nbytes); i++)
                dmem[(wr_addr - DST_BASE + i) & 4095] <= wr_data[8*i +: 8];
    end

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) if (cyc > 190000) begin
        failures++;
        $display("FAIL watchdog: global cycle limit reached");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bpp_of(input int f);
        return (f == 0) ? 4 : (f == 1) ? 3 : 2;
    endfunction

    // reference decode, returns {r,g,b,a}
    function automatic logic [31:0] rdec(input int f, input logic [31:0] w);
        int r, g, b, a, p;
        p = w & 32'hFFFF;
        case (f)
            0: begin r = w >> 24; g = (w >> 16) & 255; b = (w >> 8) & 255; a = w & 255; end
            1: begin r = (w >> 16) & 255; g = (w >> 8) & 255; b = w & 255; a = 255; end
            2: begin r = p >> 11; g = (p >> 5) & 63; b = p & 31;
                     r = (r << 3) | (r >> 2); g = (g << 2) | (g >> 4); b = (b << 3) | (b >> 2);
                     a = 255; end
            3: begin r = p >> 11; g = (p >> 6) & 31; b = (p >> 1) & 31;
                     r = (r << 3) | (r >> 2); g = (g << 3) | (g >> 2); b = (b << 3) | (b >> 2);
                     a = (p & 1) * 255; end
            4: begin r = (p >> 12) * 17; g = ((p >> 8) & 15) * 17; b = ((p >> 4) & 15) * 17;
                     a = (p & 15) * 17; end
            default: begin r = 0; g = 0; b = 0; a = 0; end
        endcase
        return {8'(r), 8'(g), 8'(b), 8'(a)};
    endfunction

    function automatic logic [31:0] renc(input int f, input int r, input int g, input int b,
                                         input int a);
        case (f)
            0: return (r << 24) | (g << 16) | (b << 8) | a;
            1: return (r << 16) | (g << 8) | b;
            2: return ((r / 8) << 11) | ((g / 4) << 5) | (b / 8);
            3: return ((r / 8) << 11) | ((g / 8) << 6) | ((b / 8) << 1) | (a / 128);
            default: return ((r / 16) << 12) | ((g / 16) << 8) | ((b / 16) << 4) | (a / 16);
        endcase
    endfunction

    function automatic int rtile(input int x, input int y, input int w);
        int m = 0;
        for (int i = 0; i < 3; i++) begin
            m += ((x >> i) & 1) << (2 * i);
            m += ((y >> i) & 1) << (2 * i + 1);
        end
        return (x / 8) * 64 + m + (y / 8) * 8 * w;
    endfunction

    function automatic logic [31:0] sword(input int addr);
        return {smem[(addr + 3) & 4095], smem[(addr + 2) & 4095],
                smem[(addr + 1) & 4095], smem[addr & 4095]};
    endfunction

    task automatic run_xfer(input string req, input int iw, input int ih, input int ow_c,
                            input int oh_c, input int fi, input int fo, input int sc,
                            input bit fl, input bit li, input bit ns, input bit poke);
        int hsh, vsh, ow, oh, n, sb, db, nrd, nwr, ndone, cnt;
        int sum [4];
        bit bad, stiled, dtiled;
        logic [31:0] px, ew;
        hsh = (sc == 1 || sc == 2) ? 1 : 0;
        vsh = (sc == 2) ? 1 : 0;
        ow = ow_c >> hsh; oh = oh_c >> vsh;
        n = 1 << (hsh + vsh);
        sb = bpp_of(fi); db = bpp_of(fo);
        bad = (iw == 0 || ih == 0 || ow_c == 0 || oh_c == 0 || sc == 3 || (li && sc != 0) ||
               fo > 4 || ow == 0 || oh == 0);
        stiled = !li; dtiled = (li != ns);
        for (int i = 0; i < 4096; i++) begin dmem[i] = 8'hEE; emem[i] = 8'hEE; end
        if (!bad)
            for (int y = 0; y < oh; y++)
                for (int x = 0; x < ow; x++) begin
                    int ix, iy, so, dof, oy;
                    ix = x << hsh; iy = y << vsh;
                    so = stiled ? rtile(ix, iy, iw) * sb : (iy * iw + ix) * sb;
                    for (int c = 0; c < 4; c++) sum[c] = 0;
                    for (int k = 0; k < n; k++) begin
                        px = rdec(fi, sword(int'(SRC_BASE) + so + k * sb));
                        for (int c = 0; c < 4; c++) sum[c] += (px >> (8 * c)) & 255;
                    end
                    oy = fl ? (oh - 1 - y) : y;
                    dof = dtiled ? rtile(x, oy, ow) * db : (oy * ow + x) * db;
                    ew = renc(fo, sum[3] / n, sum[2] / n, sum[1] / n, sum[0] / n);
                    for (int i = 0; i < db; i++) emem[(dof + i) & 4095] = ew[8*i +: 8];
                end
        @(negedge clk);
        in_w = DW'(iw); in_h = DW'(ih); out_w = DW'(ow_c); out_h = DW'(oh_c);
        in_fmt = 3'(fi); out_fmt = 3'(fo); scale = 2'(sc);
        flip = fl; lin_in = li; no_swizzle = ns; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nrd = 0; nwr = 0; ndone = 0; cnt = 0;
        while (ndone == 0 && cnt < 20000) begin
            if (rd_en) nrd++;
            if (wr_en) nwr++;
            if (done) ndone++;
            if (poke && cnt == 5) begin
                start = 1'b1; out_fmt = 3'((fo + 1) % 5); flip = !fl; in_w = DW'(iw + 8);
            end else if (poke && cnt == 6) begin
                start = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        check(cnt < 20000, req, "watchdog per transfer", cnt, 0);
        check(!done && !busy, "R10", "done one cycle then idle", {done, busy}, 0);
        check(nwr == (bad ? 0 : ow * oh), req, "write count", nwr, bad ? 0 : ow * oh);
        check(nrd == (bad ? 0 : ow * oh * n), req, "read count", nrd, bad ? 0 : ow * oh * n);
        for (int i = 0; i < 4096; i++)
            if (dmem[i] !== emem[i]) begin
                check(1'b0, req, $sformatf("dst byte %0d", i), dmem[i], emem[i]);
                break;
            end
            else if (i == 4095) check(1'b1, req, "dst image", 0, 0);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy, "R10", "no restart after poke", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) smem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_en && !wr_en, "R10", "reset state",
              {busy, done, rd_en, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R6 R7: every format pair, tiled source to linear destination
        for (int fi = 0; fi < 5; fi++)
            for (int fo = 0; fo < 5; fo++)
                run_xfer("R1", 8, 8, 8, 8, fi, fo, 0, 0, 0, 0, 0);
        // R4 R5 R8 R7: downscale over both modes, flip and swizzle settings
        for (int sc = 1; sc < 3; sc++)
            for (int fl = 0; fl < 2; fl++)
                for (int ns = 0; ns < 2; ns++) begin
                    run_xfer("R5", 16, 16, 16, 16, 0, 2, sc, 1'(fl), 0, 1'(ns), 0);
                    run_xfer("R4", 16, 16, 16, 16, 4, 3, sc, 1'(fl), 0, 1'(ns), 0);
                end
        // R6 R7 R8: linear source, both destination layouts, widths past one tile
        for (int ns = 0; ns < 2; ns++)
            for (int fl = 0; fl < 2; fl++)
                run_xfer("R7", 16, 16, 16, 16, 1, 0, 0, 1'(fl), 1, 1'(ns), 0);
        run_xfer("R6", 24, 16, 24, 16, 3, 1, 0, 1, 0, 1, 0);
        run_xfer("R8", 5, 3, 5, 3, 2, 0, 0, 1, 1, 1, 0);
        // R3: unknown input formats decode to zero
        run_xfer("R3", 8, 8, 8, 8, 6, 0, 0, 0, 0, 0, 0);
        run_xfer("R3", 16, 8, 16, 8, 5, 4, 1, 0, 0, 0, 0);
        // R9: rejected transfers
        run_xfer("R9", 0, 8, 8, 8, 0, 0, 0, 0, 0, 0, 0);
        run_xfer("R9", 8, 0, 8, 8, 0, 0, 0, 0, 0, 0, 0);
        run_xfer("R9", 8, 8, 0, 8, 0, 0, 0, 0, 0, 0, 0);
        run_xfer("R9", 8, 8, 8, 0, 0, 0, 0, 0, 0, 0, 0);
        run_xfer("R9", 8, 8, 8, 8, 0, 0, 3, 0, 0, 0, 0);
        run_xfer("R9", 8, 8, 8, 8, 0, 0, 1, 0, 1, 0, 0);
        run_xfer("R9", 8, 8, 8, 8, 0, 6, 0, 0, 0, 0, 0);
        run_xfer("R9", 8, 8, 1, 8, 0, 0, 1, 0, 0, 0, 0);
        run_xfer("R9", 8, 8, 8, 1, 0, 0, 2, 0, 0, 0, 0);
        // R10: start and config changes while busy are ignored
        run_xfer("R10", 16, 16, 16, 16, 0, 1, 2, 0, 0, 0, 1);
        run_xfer("R10", 8, 8, 8, 8, 2, 4, 0, 1, 1, 0, 1);
        summary();
        $finish;
    end
endmodule